// File: doc/BRIEF.md
# Rounding Signed Integer Divider with Arithmetic Flags

This block is the integer divide unit of a small controller's execution path. It takes a signed dividend and a signed divisor, both `DW` bits wide (16 by default), with a start pulse. It works out the quotient over a fixed number of clock cycles. The destination result is the quotient rounded to the nearest integer. A separate `2*DW`-bit math register receives the raw truncated quotient in its upper word and the remainder in its lower word. The same completion also rewrites four arithmetic status bits (carry, overflow, zero, sign) and may set a sticky minor-error flag.

When the rounded result does not fit in `DW` signed bits, a mode input sampled with the start pulse selects what happens. Either the destination clamps to the most positive or most negative value, or it keeps the low `DW` bits of the rounded result. A zero divisor counts as an overflow and leaves the math register untouched. The divide runs as a restoring divide on magnitudes, followed by a sign fix-up. The unit holds one operation at a time and ignores start pulses while busy.

Top module: `rdiv_unit`

## Requirements
- R1: When no overflow occurs, `dest` equals the quotient rounded to the nearest integer. The magnitude of the truncated quotient is raised by one exactly when twice the absolute remainder is at least the absolute divisor.
- R2: For a nonzero divisor, `math_reg[2*DW-1:DW]` receives the truncated quotient (low `DW` bits, two's complement) and `math_reg[DW-1:0]` receives the remainder, which carries the sign of the dividend. This update happens even when the destination overflows.
- R3: On every completed divide `flag_c` is 0, `flag_z` is 1 exactly when `dest` is zero, and `flag_s` equals `dest[DW-1]`.
- R4: `flag_v` is 1 when the rounded quotient lies outside [-2^(DW-1), 2^(DW-1)-1] or the divisor is zero, and 0 otherwise. The most negative dividend divided by -1 is one such case.
- R5: On overflow with `ovf_sel` = 0 and a nonzero divisor, `dest` is 2^(DW-1)-1 if the true result is positive and -2^(DW-1) if it is negative.
- R6: On overflow with `ovf_sel` = 1 and a nonzero divisor, `dest` holds the low `DW` bits of the rounded quotient.
- R7: With a zero divisor, in either mode, `dest` is -2^(DW-1) for a negative dividend and 2^(DW-1)-1 otherwise, and `math_reg` keeps its previous value.
- R8: `minor_err` is set by any completed divide that overflows. It stays set until `err_clr` is high at a clock edge where no overflowing divide completes. It is 0 after reset.
- R9: A start accepted at clock edge k gives `done` high for exactly one cycle, from edge k+DW+1. `busy` is high from edge k until that edge. Operands and `ovf_sel` are sampled only at edge k.
- R10: A start pulse while `busy` is high is ignored. The running divide completes with its own operands and on its own schedule.
- R11: During reset, `busy`, `done`, `dest`, `math_reg`, all four status bits and `minor_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide when idle |
| err_clr | input | 1 | Clears the sticky minor-error flag |
| ovf_sel | input | 1 | Overflow mode: 0 clamp, 1 keep low bits |
| a_in | input | DW | Signed dividend |
| b_in | input | DW | Signed divisor |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| dest | output | DW | Rounded signed result |
| math_reg | output | 2*DW | Truncated quotient (upper word) and remainder (lower word) |
| flag_c | output | 1 | Carry status, always cleared |
| flag_v | output | 1 | Overflow status |
| flag_z | output | 1 | Zero status of `dest` |
| flag_s | output | 1 | Sign status of `dest` |
| minor_err | output | 1 | Sticky minor-error flag |

## Verification
Every result of a divide (`dest`, `math_reg`, the four status bits and `minor_err`) updates on the single edge DW+1 cycles after the accepting edge, and `done` falls one edge later. The bench drives inputs on falling edges and counts falling edges from the accept. It checks `busy` partway through, checks that `done` stays low before falling edge DW+2 and is high there, and compares all results at that point. It then checks that `done` is low at the following falling edge. A stray start is applied mid-operation together with scrambled operands, and the clearing of `minor_err` is sampled one falling edge after the `err_clr` pulse.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_RUN  = 2'd1,
    RD_FIN  = 2'd2
  } rd_state_e;

  typedef struct packed {
    logic c;
    logic v;
    logic z;
    logic s;
  } rd_flags_t;

endpackage

// File: rtl/rdiv_core.sv
module rdiv_core
  import rdiv_pkg::*;
#(
  parameter int DW = 16,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          ovf_sel,
  output logic          busy,
  output logic          fin,
  output logic          neg_res,
  output logic          a_neg,
  output logic          div0,
  output logic          mode,
  output logic [DW-1:0] qmag,
  output logic [DW-1:0] rmag,
  output logic [DW-1:0] bmag
);

  function automatic logic [DW-1:0] f_abs(input logic [DW-1:0] x);
    return x[DW-1] ? (~x + 1'b1) : x;
  endfunction

  rd_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] rem_q, quo_q, bmag_q;
  logic          sa_q, sb_q, mode_q, div0_q;

  logic [DW:0]   rem_sh, rem_sub;
  logic          take;
  logic          unused_top;

  // one restoring step: shift in the next dividend bit, trial-subtract
  always_comb begin
    rem_sh  = {rem_q, quo_q[DW-1]};
    take    = (rem_sh >= {1'b0, bmag_q});
    rem_sub = rem_sh - {1'b0, bmag_q};
  end
  assign unused_top = rem_sub[DW] ^ rem_sh[DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      bmag_q  <= '0;
      sa_q    <= 1'b0;
      sb_q    <= 1'b0;
      mode_q  <= 1'b0;
      div0_q  <= 1'b0;
    end else begin
      case (state_q)
        RD_IDLE: if (start) begin
          state_q <= RD_RUN;
          cnt_q   <= CW'(DW);
          rem_q   <= '0;
          quo_q   <= f_abs(a_in);
          bmag_q  <= f_abs(b_in);
          sa_q    <= a_in[DW-1];
          sb_q    <= b_in[DW-1];
          mode_q  <= ovf_sel;
          div0_q  <= (b_in == '0);
        end
        RD_RUN: begin
          rem_q <= take ? rem_sub[DW-1:0] : rem_sh[DW-1:0];
          quo_q <= {quo_q[DW-2:0], take};
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) state_q <= RD_FIN;
        end
        RD_FIN:  state_q <= RD_IDLE;
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != RD_IDLE);
  assign fin     = (state_q == RD_FIN);
  assign neg_res = sa_q ^ sb_q;
  assign a_neg   = sa_q;
  assign div0    = div0_q;
  assign mode    = mode_q;
  assign qmag    = quo_q;
  assign rmag    = rem_q;
  assign bmag    = bmag_q;

endmodule

// File: rtl/rdiv_round.sv
module rdiv_round
  import rdiv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            neg_res,
  input  logic            a_neg,
  input  logic            div0,
  input  logic            mode,
  input  logic [DW-1:0]   qmag,
  input  logic [DW-1:0]   rmag,
  input  logic [DW-1:0]   bmag,
  output logic [DW-1:0]   dest,
  output logic [2*DW-1:0] math_word,
  output logic            math_we,
  output logic            ovf,
  output rd_flags_t       flags
);

  localparam logic [DW:0]   MAG_NEG = {2'b01, {(DW-1){1'b0}}};
  localparam logic [DW:0]   MAG_POS = {2'b00, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SAT_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SAT_MIN = {1'b1, {(DW-1){1'b0}}};

  // round half away from zero: 2*|r| >= |b|
  function automatic logic f_round_up(input logic [DW-1:0] r, input logic [DW-1:0] b);
    return {r, 1'b0} >= {1'b0, b};
  endfunction

  function automatic logic [DW-1:0] f_neg(input logic [DW-1:0] x);
    return ~x + 1'b1;
  endfunction

  function automatic logic f_out_of_range(input logic [DW:0] m, input logic neg);
    return neg ? (m > MAG_NEG) : (m > MAG_POS);
  endfunction

  logic          up, too_big;
  logic [DW:0]   rnd_mag;
  logic [DW-1:0] rnd_val, q_s, r_s, sat;

  always_comb begin
    up      = f_round_up(rmag, bmag);
    rnd_mag = {1'b0, qmag} + {{DW{1'b0}}, up};
    too_big = f_out_of_range(rnd_mag, neg_res);
    rnd_val = neg_res ? f_neg(rnd_mag[DW-1:0]) : rnd_mag[DW-1:0];
    q_s     = neg_res ? f_neg(qmag) : qmag;
    r_s     = a_neg ? f_neg(rmag) : rmag;
    sat     = neg_res ? SAT_MIN : SAT_MAX;
    math_word = {q_s, r_s};
    if (div0) begin
      ovf     = 1'b1;
      math_we = 1'b0;
      dest    = a_neg ? SAT_MIN : SAT_MAX;
    end else begin
      ovf     = too_big;
      math_we = 1'b1;
      dest    = (too_big && !mode) ? sat : rnd_val;
    end
    flags.c = 1'b0;
    flags.v = ovf;
    flags.z = (dest == '0);
    flags.s = dest[DW-1];
  end

endmodule

// File: rtl/rdiv_unit.sv
module rdiv_unit
  import rdiv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            err_clr,
  input  logic            ovf_sel,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   b_in,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   dest,
  output logic [2*DW-1:0] math_reg,
  output logic            flag_c,
  output logic            flag_v,
  output logic            flag_z,
  output logic            flag_s,
  output logic            minor_err
);

  // named internal events for the checker
  logic            fin_evt, ovf_evt, div0_evt, mode_w, acc_evt;
  logic            neg_w, aneg_w, math_we;
  logic [DW-1:0]   qmag_w, rmag_w, bmag_w, dest_w;
  logic [2*DW-1:0] math_w;
  rd_flags_t       flags_w, flags_q;
  logic [DW-1:0]   dest_q;
  logic [2*DW-1:0] math_q;
  logic            done_q, minor_q;

  rdiv_core #(.DW(DW)) core_i (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .ovf_sel(ovf_sel), .busy(busy), .fin(fin_evt), .neg_res(neg_w),
    .a_neg(aneg_w), .div0(div0_evt), .mode(mode_w),
    .qmag(qmag_w), .rmag(rmag_w), .bmag(bmag_w)
  );

  rdiv_round #(.DW(DW)) round_i (
    .neg_res(neg_w), .a_neg(aneg_w), .div0(div0_evt), .mode(mode_w),
    .qmag(qmag_w), .rmag(rmag_w), .bmag(bmag_w),
    .dest(dest_w), .math_word(math_w), .math_we(math_we),
    .ovf(ovf_evt), .flags(flags_w)
  );

  assign acc_evt = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q  <= '0;
      math_q  <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
      minor_q <= 1'b0;
    end else begin
      done_q <= fin_evt;
      if (fin_evt) begin
        dest_q  <= dest_w;
        flags_q <= flags_w;
        if (math_we) math_q <= math_w;
      end
      if (fin_evt && ovf_evt) minor_q <= 1'b1;
      else if (err_clr)       minor_q <= 1'b0;
    end
  end

  assign done      = done_q;
  assign dest      = dest_q;
  assign math_reg  = math_q;
  assign flag_c    = flags_q.c;
  assign flag_v    = flags_q.v;
  assign flag_z    = flags_q.z;
  assign flag_s    = flags_q.s;
  assign minor_err = minor_q;

endmodule

// File: rtl/rdiv_unit_chk.sv
module rdiv_unit_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            err_clr,
  input logic            busy,
  input logic            done,
  input logic            acc_evt,
  input logic            fin_evt,
  input logic            ovf_evt,
  input logic            div0_evt,
  input logic            mode_w,
  input logic [DW-1:0]   dest,
  input logic [2*DW-1:0] math_reg,
  input logic            flag_c,
  input logic            flag_v,
  input logic            flag_z,
  input logic            flag_s,
  input logic            minor_err
);

  localparam logic [DW-1:0] SAT_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SAT_MIN = {1'b1, {(DW-1){1'b0}}};

  a_r3_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flag_c);

  a_r3_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == (dest == '0)) && (flag_s == dest[DW-1]));

  a_r4_ovf_sets_minor: assert property (@(posedge clk) disable iff (!rst_n)
    done && flag_v |-> minor_err);

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt && ovf_evt && !mode_w |=> (dest == SAT_MAX) || (dest == SAT_MIN));

  a_r7_math_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt && div0_evt |=> $stable(math_reg));

  a_r8_minor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    minor_err && !err_clr |=> minor_err);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_fin_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> done && !busy);

  a_r9_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> busy && !done);

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy && !fin_evt |=> busy && !done);

endmodule

bind rdiv_unit rdiv_unit_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .err_clr(err_clr),
  .busy(busy), .done(done), .acc_evt(acc_evt), .fin_evt(fin_evt),
  .ovf_evt(ovf_evt), .div0_evt(div0_evt), .mode_w(mode_w),
  .dest(dest), .math_reg(math_reg), .flag_c(flag_c), .flag_v(flag_v),
  .flag_z(flag_z), .flag_s(flag_s), .minor_err(minor_err)
);

// File: tb/rdiv_unit_tb_top.sv
module rdiv_unit_tb_top;

  localparam int DW   = 6;
  localparam int MAXV = (1 << (DW - 1)) - 1;
  localparam int MINV = -(1 << (DW - 1));

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0, err_clr = 1'b0, ovf_sel = 1'b0;
  logic [DW-1:0]   a_in = '0, b_in = '0;
  logic            busy, done, flag_c, flag_v, flag_z, flag_s, minor_err;
  logic [DW-1:0]   dest;
  logic [2*DW-1:0] math_reg;

  int n_chk = 0;
  int n_err = 0;
  logic [2*DW-1:0] last_math = '0;
  bit exp_minor = 1'b0;
  int op_idx = 0;

  always #2 clk = ~clk;

  rdiv_unit #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .err_clr(err_clr),
    .ovf_sel(ovf_sel), .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
    .dest(dest), .math_reg(math_reg), .flag_c(flag_c), .flag_v(flag_v),
    .flag_z(flag_z), .flag_s(flag_s), .minor_err(minor_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic run_div(input int a, input int b, input bit m);
    int q, r, rq;
    bit ev, early;
    logic [DW-1:0]   ed;
    logic [2*DW-1:0] em;
    string dreq;
    if (b == 0) begin
      ev = 1'b1;
      ed = (a < 0) ? MINV[DW-1:0] : MAXV[DW-1:0];
      em = last_math;
      dreq = "R7";
    end else begin
      q  = a / b;
      r  = a % b;
      rq = q;
      if (2 * iabs(r) >= iabs(b)) rq = ((a < 0) != (b < 0)) ? q - 1 : q + 1;
      ev = (rq > MAXV) || (rq < MINV);
      if (!ev)   ed = rq[DW-1:0];
      else if (m) ed = rq[DW-1:0];
      else       ed = (rq < 0) ? MINV[DW-1:0] : MAXV[DW-1:0];
      em = {q[DW-1:0], r[DW-1:0]};
      dreq = !ev ? "R1" : (m ? "R6" : "R5");
    end
    @(negedge clk);
    a_in = a[DW-1:0]; b_in = b[DW-1:0]; ovf_sel = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a_in = ~a_in; b_in = b_in + 1'b1; ovf_sel = ~m;
    chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
    early = 1'b0;
    for (int k = 2; k <= DW + 1; k++) begin
      if (k == 2) start = 1'b1;   // stray start while busy (R10)
      if (k == 3) start = 1'b0;
      @(negedge clk);
      if (done) early = 1'b1;
      if (k == 3) chk(busy == 1'b1, "R10", "busy after stray start", busy, 1);
    end
    @(negedge clk);
    chk(!early && done, "R9", "done timing", {early, done}, 1);
    chk(busy == 1'b0, "R9", "busy at done", busy, 0);
    chk(dest == ed, dreq, "dest", dest, ed);
    chk(math_reg == em, (b == 0) ? "R7" : "R2", "math_reg", math_reg, em);
    chk(flag_v == ev, "R4", "flag_v", flag_v, ev);
    chk(flag_c == 1'b0, "R3", "flag_c", flag_c, 0);
    chk(flag_z == (ed == '0), "R3", "flag_z", flag_z, (ed == '0));
    chk(flag_s == ed[DW-1], "R3", "flag_s", flag_s, ed[DW-1]);
    exp_minor = exp_minor | ev;
    chk(minor_err == exp_minor, "R8", "minor_err", minor_err, exp_minor);
    last_math = em;
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single pulse", done, 0);
    op_idx++;
    if ((op_idx % 5) == 0) begin
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      exp_minor = 1'b0;
      chk(minor_err == 1'b0, "R8", "minor_err after clear", minor_err, 0);
    end
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy == 0 && done == 0, "R11", "busy/done in reset", {busy, done}, 0);
    chk(dest == 0 && math_reg == 0, "R11", "data in reset", {dest, math_reg}, 0);
    chk({flag_c, flag_v, flag_z, flag_s, minor_err} == 0, "R11", "flags in reset",
        {flag_c, flag_v, flag_z, flag_s, minor_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int a = MINV; a <= MAXV; a++)
        for (int b = MINV; b <= MAXV; b++)
          run_div(a, b, m[0]);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule